// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a simple valid/ready request port and an asynchronous static RAM of 524,288 sixteen-bit words. Each accepted request is one word, either a read or a write. The block turns it into a strobe sequence on the RAM pins: address, two chip enables of opposite polarity, a low and a high byte enable, output enable, write enable and a split data bus (output value, output-enable and input value). Only one request is in flight at a time.

Every RAM timing limit is a nanosecond parameter. The block turns each limit into a whole number of clock cycles by rounding up against the clock-period parameter. A write may carry a byte mask, so only the selected lanes are stored. Read data is registered and returned with a single response pulse. When the bus direction changes from a read to a write, or from a write to a read, the block inserts turnaround cycles so the controller and the RAM never drive the data bus at the same time. When no access is in progress, every strobe sits at its inactive level, which puts the RAM in standby.

Top module: `sram_bus_ctl`

## Requirements
- R1: After reset and whenever `req_ready` is high, the RAM pins are idle: `ram_ce1_n`=1, `ram_ce2`=0, `ram_lb_n`=`ram_ub_n`=1, `ram_oe_n`=1, `ram_we_n`=1 and `ram_dq_oe`=0.
- R2: During a read, `ram_ce1_n`=0, `ram_ce2`=1, `ram_we_n`=1 and `ram_oe_n`=0. `req_be[0]` enables the low lane (bits 7:0, `ram_lb_n` low) and `req_be[1]` enables the high lane (bits 15:8, `ram_ub_n` low). In `rsp_rdata`, any lane that was not enabled reads as zero.
- R3: Each read gives exactly one `rsp_valid` pulse, one cycle long. It comes in the cycle after the last access cycle. With no turnaround, that is ACC_CYC clock edges after the accepting edge.
- R4: A write holds `ram_we_n` low for exactly WP_CYC cycles, with the chip selected. Only lanes whose `req_be` bit is 1 are stored. A write with `req_be`=0 changes nothing.
- R5: `ram_dq_oe` is high only while `ram_we_n` is low, or in the single cycle just before it falls.
- R6: The address, chip enables and byte enables stay unchanged from the first write-pulse cycle through the cycle after `ram_we_n` rises.
- R7: A read that follows a write waits OHZ_CYC extra cycles before `ram_oe_n` falls, so its response comes ACC_CYC+OHZ_CYC edges after acceptance. A write that follows a read keeps the bus released, with `ram_oe_n` high, for at least OHZ_CYC+1 cycles before it drives data.
- R8: `req_ready` is high only while idle, and a request is taken on a clock edge with `req_valid` and `req_ready` both high. A new request can be accepted in the same cycle as the previous read's response.
- R9: `ram_dq_oe` and a low `ram_oe_n` never occur in the same cycle.
- R10: Cycle counts are ceil(ns*1000/CLK_PS) with a minimum of 1. ACC_CYC is the largest of the access, cycle-time and output-enable counts. WP_CYC is the largest of the pulse-width, address-to-end and data-setup counts. At the defaults (10 ns clock) this gives ACC_CYC=6, WP_CYC=5 and OHZ_CYC=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, active high (bit 0 = low lane) |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ram_addr | output | 19 | RAM address |
| ram_dq_o | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Controller drives the data bus |
| ram_dq_i | input | 16 | Data read from the RAM bus |
| ram_ce1_n | output | 1 | Chip enable, active low |
| ram_ce2 | output | 1 | Chip enable, active high |
| ram_lb_n | output | 1 | Low-lane enable, active low |
| ram_ub_n | output | 1 | High-lane enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_we_n | output | 1 | Write enable, active low |

## Verification
A read's response pulse and the acceptance of the next request can land in the same cycle. The controller goes back to idle in the same cycle it raises `rsp_valid`. The bench provokes this by keeping the next request pending while a read completes. The scoreboard then pops the first read's expected word and latency in that same cycle, and the RAM model sees the new access start one edge later. The run must record at least one such overlap, and both operations must still match their own expected data and timing.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int SRAM_AW    = 19;
    localparam int SRAM_DW    = 16;
    localparam int SRAM_LANES = 2;
    localparam int LANE_W     = SRAM_DW / SRAM_LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RTURN,
        ST_RACC,
        ST_WTURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WREC
    } sram_state_e;

    typedef struct packed {
        logic                  wr;
        logic [SRAM_AW-1:0]    addr;
        logic [SRAM_DW-1:0]    wdata;
        logic [SRAM_LANES-1:0] be;
    } sram_req_t;

    // ceil(ns / period) with period in picoseconds, never below one cycle
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          done
);

    logic [TW-1:0] cnt;

    // a phase loaded with N lasts N cycles; done marks its last one
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val - TW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          active,
    input  logic          cap,
    input  logic [BW-1:0] dq_in,
    output logic          be_n,
    output logic [BW-1:0] rdata
);

    assign be_n = !(active && en);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (cap) begin
            rdata <= en ? dq_in : '0;
        end
    end

endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PS    = 10000,
    parameter int T_ACC_NS  = 55,
    parameter int T_RC_NS   = 55,
    parameter int T_OE_NS   = 25,
    parameter int T_OHZ_NS  = 20,
    parameter int T_WP_NS   = 40,
    parameter int T_AW_NS   = 50,
    parameter int T_DW_NS   = 25,
    parameter int T_WC_NS   = 55
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [SRAM_AW-1:0]    req_addr,
    input  logic [SRAM_DW-1:0]    req_wdata,
    input  logic [SRAM_LANES-1:0] req_be,
    output logic                  rsp_valid,
    output logic [SRAM_DW-1:0]    rsp_rdata,
    output logic [SRAM_AW-1:0]    ram_addr,
    output logic [SRAM_DW-1:0]    ram_dq_o,
    output logic                  ram_dq_oe,
    input  logic [SRAM_DW-1:0]    ram_dq_i,
    output logic                  ram_ce1_n,
    output logic                  ram_ce2,
    output logic                  ram_lb_n,
    output logic                  ram_ub_n,
    output logic                  ram_oe_n,
    output logic                  ram_we_n
);

    localparam int ACC_CYC = max3(ns_to_cyc(T_ACC_NS, CLK_PS),
                                  ns_to_cyc(T_RC_NS,  CLK_PS),
                                  ns_to_cyc(T_OE_NS,  CLK_PS));
    localparam int WP_CYC  = max3(ns_to_cyc(T_WP_NS, CLK_PS),
                                  ns_to_cyc(T_AW_NS, CLK_PS),
                                  ns_to_cyc(T_DW_NS, CLK_PS));
    localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PS);
    localparam int REC_CYC = (WC_CYC - WP_CYC - 1 < 1) ? 1 : WC_CYC - WP_CYC - 1;
    localparam int OHZ_CYC = ns_to_cyc(T_OHZ_NS, CLK_PS);
    localparam int MAX_CYC = max3(max3(ACC_CYC, WP_CYC, REC_CYC), OHZ_CYC, 1);
    localparam int TW      = $clog2(MAX_CYC + 1);

    sram_state_e st, st_n;
    sram_req_t   req_q;
    logic        last_rd, last_wr;
    logic        accept, cap, strobe_on;
    logic        t_load, t_done;
    logic [TW-1:0] t_val;
    logic [SRAM_LANES-1:0] be_n_vec;

    // phase sequencing
    always_comb begin
        st_n   = st;
        t_load = 1'b0;
        t_val  = TW'(1);
        accept = 1'b0;
        cap    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    t_load = 1'b1;
                    if (req_write) begin
                        if (last_rd) begin
                            st_n  = ST_WTURN;
                            t_val = TW'(OHZ_CYC);
                        end else begin
                            st_n  = ST_WSETUP;
                            t_val = TW'(1);
                        end
                    end else begin
                        if (last_wr) begin
                            st_n  = ST_RTURN;
                            t_val = TW'(OHZ_CYC);
                        end else begin
                            st_n  = ST_RACC;
                            t_val = TW'(ACC_CYC);
                        end
                    end
                end
            end
            ST_RTURN: begin
                if (t_done) begin
                    st_n   = ST_RACC;
                    t_load = 1'b1;
                    t_val  = TW'(ACC_CYC);
                end
            end
            ST_RACC: begin
                if (t_done) begin
                    st_n = ST_IDLE;
                    cap  = 1'b1;
                end
            end
            ST_WTURN: begin
                if (t_done) begin
                    st_n   = ST_WSETUP;
                    t_load = 1'b1;
                    t_val  = TW'(1);
                end
            end
            ST_WSETUP: begin
                if (t_done) begin
                    st_n   = ST_WPULSE;
                    t_load = 1'b1;
                    t_val  = TW'(WP_CYC);
                end
            end
            ST_WPULSE: begin
                if (t_done) begin
                    st_n   = ST_WREC;
                    t_load = 1'b1;
                    t_val  = TW'(REC_CYC);
                end
            end
            ST_WREC: begin
                if (t_done) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            req_q     <= '0;
            last_rd   <= 1'b0;
            last_wr   <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            st        <= st_n;
            rsp_valid <= cap;
            if (accept) begin
                req_q.wr    <= req_write;
                req_q.addr  <= req_addr;
                req_q.wdata <= req_wdata;
                req_q.be    <= req_be;
            end
            if (cap) begin
                last_rd <= 1'b1;
                last_wr <= 1'b0;
            end else if (st == ST_WREC && t_done) begin
                last_rd <= 1'b0;
                last_wr <= 1'b1;
            end
        end
    end

    sram_phase_timer #(.TW(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .val  (t_val),
        .done (t_done)
    );

    assign strobe_on = (st == ST_RACC) || (st == ST_WSETUP) ||
                       (st == ST_WPULSE) || (st == ST_WREC);

    for (genvar g = 0; g < SRAM_LANES; g++) begin : g_lane
        sram_byte_lane #(.BW(LANE_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .en     (req_q.be[g]),
            .active (strobe_on),
            .cap    (cap),
            .dq_in  (ram_dq_i[g*LANE_W +: LANE_W]),
            .be_n   (be_n_vec[g]),
            .rdata  (rsp_rdata[g*LANE_W +: LANE_W])
        );
    end

    assign req_ready = (st == ST_IDLE);
    assign ram_addr  = req_q.addr;
    assign ram_dq_o  = req_q.wdata;
    assign ram_dq_oe = (st == ST_WSETUP) || (st == ST_WPULSE);
    assign ram_ce1_n = !strobe_on;
    assign ram_ce2   = strobe_on;
    assign ram_lb_n  = be_n_vec[0];
    assign ram_ub_n  = be_n_vec[SRAM_LANES-1];
    assign ram_oe_n  = (st != ST_RACC);
    assign ram_we_n  = (st != ST_WPULSE);

endmodule

// File: rtl/sram_bus_ctl_chk.sv
module sram_bus_ctl_chk #(
    parameter int OHZ_CYC = 2,
    parameter int AW      = 19
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] ram_addr,
    input logic          ram_dq_oe,
    input logic          ram_ce1_n,
    input logic          ram_ce2,
    input logic          ram_lb_n,
    input logic          ram_ub_n,
    input logic          ram_oe_n,
    input logic          ram_we_n
);

    logic [7:0] oe_hi_cnt, we_hi_cnt;

    // cycles already spent with each strobe high, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_hi_cnt <= 8'hFF;
            we_hi_cnt <= 8'hFF;
        end else begin
            oe_hi_cnt <= !ram_oe_n ? 8'd0 : (oe_hi_cnt == 8'hFF ? oe_hi_cnt : oe_hi_cnt + 8'd1);
            we_hi_cnt <= !ram_we_n ? 8'd0 : (we_hi_cnt == 8'hFF ? we_hi_cnt : we_hi_cnt + 8'd1);
        end
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ram_ce1_n && !ram_ce2 && ram_lb_n && ram_ub_n &&
                       ram_oe_n && ram_we_n && !ram_dq_oe));

    assert_read_select_R2: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |-> (!ram_ce1_n && ram_ce2 && ram_we_n));

    assert_rsp_single_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_write_select_R4: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (!ram_ce1_n && ram_ce2 && ram_oe_n));

    assert_drive_lead_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_dq_oe) |=> !ram_we_n);

    assert_drive_in_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> ram_dq_oe);

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |=> ($stable(ram_addr) && $stable(ram_lb_n) &&
                       $stable(ram_ub_n) && !ram_ce1_n && ram_ce2));

    assert_rd_to_wr_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_dq_oe) |-> (oe_hi_cnt >= 8'(OHZ_CYC + 1)));

    assert_wr_to_rd_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_oe_n) |-> (we_hi_cnt >= 8'(OHZ_CYC + 2)));

    assert_take_once_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
        !(ram_dq_oe && !ram_oe_n));

endmodule

bind sram_bus_ctl sram_bus_ctl_chk #(.OHZ_CYC(OHZ_CYC), .AW(sram_ctl_pkg::SRAM_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ram_addr  (ram_addr),
    .ram_dq_oe (ram_dq_oe),
    .ram_ce1_n (ram_ce1_n),
    .ram_ce2   (ram_ce2),
    .ram_lb_n  (ram_lb_n),
    .ram_ub_n  (ram_ub_n),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n)
);

// File: tb/tb_sram_bus_ctl.sv
module tb_sram_bus_ctl;

    // expected counts at a 10 ns clock (R10): ceil(55/10)=6, ceil(50/10)=5, ceil(20/10)=2
    localparam int ACC = 6;
    localparam int WP  = 5;
    localparam int OHZ = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] ram_addr;
    logic [15:0] ram_dq_o, ram_dq_i = 16'hA5A5;
    logic        ram_dq_oe, ram_ce1_n, ram_ce2, ram_lb_n, ram_ub_n, ram_oe_n, ram_we_n;

    always #5 clk = ~clk;

    sram_bus_ctl dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i),
        .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2), .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
    );

    typedef struct {
        logic [15:0] data;
        int          acc;
        int          lat;
    } exp_t;

    exp_t        sb_q[$];
    bit   [15:0] refm [bit [18:0]];
    bit   [15:0] mem  [bit [18:0]];
    int          errors = 0, checks = 0, cyc = 0, coinc = 0;
    bit          prev_wr = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // driver: called at a falling edge, returns at a falling edge
    task automatic do_req(input bit wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
        exp_t        e;
        logic [15:0] cur;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        while (!req_ready) @(negedge clk);
        cur = refm[a];
        if (wr) begin
            if (be[0]) cur[7:0]  = d[7:0];
            if (be[1]) cur[15:8] = d[15:8];
            refm[a] = cur;
        end else begin
            e.data = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
            e.acc  = cyc + 1;
            e.lat  = ACC + (prev_wr ? OHZ : 0);
            sb_q.push_back(e);
        end
        prev_wr = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor and RAM model, sampled on the falling edge
    int          wcnt = 0, oe_hi = 255;
    bit          prev_oe_drv = 1'b0, seen_rd = 1'b0;
    logic [18:0] w_addr;
    logic [15:0] w_data;
    logic [1:0]  w_ben;

    always @(negedge clk) begin
        exp_t e;
        bit   sel;
        if (!rst) begin
            sel = !ram_ce1_n && ram_ce2;
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected response", 32'(rsp_rdata), 32'h0);
                end else begin
                    e = sb_q.pop_front();
                    chk(rsp_rdata == e.data, "R2 read data", 32'(rsp_rdata), 32'(e.data));
                    chk(cyc - e.acc == e.lat, "R3/R7/R10 read latency", 32'(cyc - e.acc), 32'(e.lat));
                end
                if (req_valid && req_ready) coinc++;
            end
            if (req_ready)
                chk(ram_ce1_n && !ram_ce2 && ram_lb_n && ram_ub_n && ram_oe_n && ram_we_n && !ram_dq_oe,
                    "R1 idle pins", {25'd0, ram_ce1_n, ram_ce2, ram_lb_n, ram_ub_n, ram_oe_n, ram_we_n, ram_dq_oe},
                    32'b1011110);
            if (ram_dq_oe) begin
                chk(ram_oe_n, "R9 bus contention", 32'(ram_oe_n), 32'd1);
                chk(!(ram_we_n && prev_oe_drv), "R5 drive window", 32'(ram_we_n), 32'd0);
                if (!prev_oe_drv && seen_rd) begin
                    chk(oe_hi >= OHZ + 1, "R7 read-to-write release", 32'(oe_hi), 32'(OHZ + 1));
                    seen_rd = 1'b0;
                end
            end
            if (!ram_oe_n) begin
                seen_rd = 1'b1;
                chk(sel && ram_we_n, "R2 read strobes", {30'd0, sel, ram_we_n}, 32'b11);
            end
            if (!ram_we_n) begin
                if (wcnt == 0) begin
                    chk(prev_oe_drv, "R5 data before pulse", 32'(prev_oe_drv), 32'd1);
                    w_addr = ram_addr;
                    w_data = ram_dq_o;
                    w_ben  = {ram_ub_n, ram_lb_n};
                end else begin
                    chk(ram_addr == w_addr && ram_dq_o == w_data && {ram_ub_n, ram_lb_n} == w_ben,
                        "R6 stable during pulse", 32'(ram_addr), 32'(w_addr));
                end
                chk(ram_dq_oe && sel, "R4 selected and driven", {30'd0, ram_dq_oe, sel}, 32'b11);
                wcnt++;
            end else if (wcnt != 0) begin
                chk(wcnt == WP, "R4/R10 write pulse width", 32'(wcnt), 32'(WP));
                chk(sel && ram_addr == w_addr && {ram_ub_n, ram_lb_n} == w_ben,
                    "R6 hold after pulse", 32'(ram_addr), 32'(w_addr));
                if (!w_ben[0]) mem[w_addr][7:0]  = w_data[7:0];
                if (!w_ben[1]) mem[w_addr][15:8] = w_data[15:8];
                wcnt = 0;
            end
            oe_hi       = !ram_oe_n ? 0 : (oe_hi < 255 ? oe_hi + 1 : oe_hi);
            prev_oe_drv = ram_dq_oe;
            ram_dq_i[7:0]  = (sel && !ram_oe_n && ram_we_n && !ram_lb_n) ? mem[ram_addr][7:0]  : 8'hA5;
            ram_dq_i[15:8] = (sel && !ram_oe_n && ram_we_n && !ram_ub_n) ? mem[ram_addr][15:8] : 8'h5A;
        end
    end

    bit finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit [18:0] pool [8];
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && ram_ce1_n && !ram_ce2 && ram_lb_n && ram_ub_n &&
            ram_oe_n && ram_we_n && !ram_dq_oe, "R1 reset state", 32'(req_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);

        do_req(1'b0, 19'h00000, 16'h0, 2'b11);          // R3: unwritten word, no turnaround
        do_req(1'b1, 19'h7FFFF, 16'h1234, 2'b11);       // top address
        do_req(1'b0, 19'h7FFFF, 16'h0, 2'b11);          // R7: write then read
        do_req(1'b1, 19'h00000, 16'hABCD, 2'b01);       // R4: low lane only
        do_req(1'b1, 19'h00000, 16'h55AA, 2'b10);       // R4: high lane only
        do_req(1'b0, 19'h00000, 16'h0, 2'b11);          // expect 55CD
        do_req(1'b0, 19'h00000, 16'h0, 2'b01);          // R2: masked read, expect 00CD
        do_req(1'b1, 19'h00000, 16'hFFFF, 2'b00);       // R4: empty mask changes nothing
        do_req(1'b0, 19'h00000, 16'h0, 2'b11);
        do_req(1'b0, 19'h7FFFF, 16'h0, 2'b10);          // R8: back-to-back reads
        do_req(1'b0, 19'h00000, 16'h0, 2'b00);          // R2: no lanes, expect 0

        pool[0] = 19'h00000;
        pool[1] = 19'h7FFFF;
        for (int i = 2; i < 8; i++) pool[i] = 19'($urandom);
        for (int i = 0; i < 150; i++) begin
            do_req(1'($urandom), pool[$urandom % 8], 16'($urandom), 2'($urandom));
        end

        while (sb_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(coinc > 0, "R8 response and acceptance in one cycle", 32'(coinc), 32'd1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule